// File: doc/BRIEF.md
# Processor Power State Sequencer

This controller steps a processor between five power states: Normal, Auto Halt, Quick Start, Deep Sleep and Off. A one-cycle request pulse carries a system sleep code and a processor idle code. The block decodes that pair into a target state. Each target state has its own memory mode (active, self-refresh or powered off) and its own clock mode (running, clocks gated, PLL powered down, or clock generator off).

The block moves to a target state in a fixed order. Memory is asked to enter self-refresh, and clocks are only removed after the memory acknowledges. On the way back, the PLL is powered up first. After it reports lock, the clocks restart, and only then is self-refresh released. A wake pulse starts this return path from any reversible low-power state. The deepest Off states, which power down memory and the clock generator, can only be left through reset. A programmable counter limits how long the block waits for PLL lock, and a sticky flag reports when that limit runs out.

Sequencer states are:
- `SQ_NORMAL`
- `SQ_HALT`
- `SQ_SR_ENTER`
- `SQ_LOWPWR`
- `SQ_EXIT_LOCK`
- `SQ_EXIT_CLK`
- `SQ_EXIT_SR`

Transitions are:
- **request:** `SQ_NORMAL`/`SQ_HALT` → `SQ_HALT`, `SQ_NORMAL` or `SQ_SR_ENTER`
- **wake:** `SQ_HALT` → `SQ_NORMAL`
- **ack:** `SQ_SR_ENTER` → `SQ_LOWPWR`
- **wake:** `SQ_LOWPWR` → `SQ_EXIT_LOCK`, `SQ_EXIT_CLK` or `SQ_EXIT_SR`, picked by the clock mode of the state being left
- **lock:** `SQ_EXIT_LOCK` → `SQ_EXIT_CLK`
- **restart:** `SQ_EXIT_CLK` → `SQ_EXIT_SR`, after one cycle
- **ack drop:** `SQ_EXIT_SR` → `SQ_NORMAL`

Top module: `pwr_state_seq`

## Requirements
- R1: After reset, `pstate` is 0 (Normal). All of these are low: `core_halt`, `sr_req`, `clk_stop`, `pll_pd`, `clkgen_off`, `sdram_off`, `busy` and `lock_timeout`.
- R2: `pstate` encodes the committed state as follows: Normal=0, Auto Halt=1, Quick Start=2, Deep Sleep=3, Off=4. It changes only when a state is reached. During an exit sequence it keeps the code of the low-power state until Normal is reached.
- R3: A request carries `req_sys` and `req_cpu`. With `req_sys`=0 (working), `req_cpu`=0 selects Normal and `req_cpu`=1 selects Auto Halt. Auto Halt raises only `core_halt`, and it is reached in one cycle without `busy`.
- R4: With `req_sys`=0 and `req_cpu`=2, the block enters Quick Start: `sr_req` high and clocks running (`clk_stop` and `pll_pd` low).
- R5: Two requests select Deep Sleep. `req_sys`=0 with `req_cpu`=3 gives `clk_stop` high with `pll_pd` low. `req_sys`=1 gives both `clk_stop` and `pll_pd` high. Self-refresh stays requested in both cases.
- R6: `req_sys`=2 or 3 selects Off with self-refresh and the PLL down. `req_sys`=4 to 7 selects Off with `sdram_off` and `clkgen_off` high as well.
- R7: `clk_stop` and `pll_pd` are raised only while `sr_ack` is high.
- R8: On exit, `pll_pd` falls first. `clk_stop` falls only after `pll_lock` is seen. `sr_req` falls only once `clk_stop` is low. The state returns to Normal after `sr_ack` drops.
- R9: A wake pulse in Auto Halt, Quick Start, Deep Sleep, or an Off state that keeps memory in self-refresh returns the block to Normal. In an Off state with the clock generator off, wake is ignored and only reset leaves the state.
- R10: `busy` is high during self-refresh entry and throughout the exit sequence. Requests that arrive while `busy` is high, or while in a self-refresh state, are ignored.
- R11: While waiting for lock, a counter compares against `lock_wait_lim`. If that many cycles pass without `pll_lock`, `lock_timeout` is set and holds until reset. The wait continues and completes when lock arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_sys | input | 3 | System sleep code (0 working, 1..7 sleep/off levels) |
| req_cpu | input | 2 | Processor idle code, used when `req_sys`=0 |
| wake | input | 1 | Wake event pulse |
| sr_ack | input | 1 | Self-refresh acknowledge from the memory controller |
| pll_lock | input | 1 | PLL lock indication |
| lock_wait_lim | input | 16 | Lock wait limit in cycles |
| core_halt | output | 1 | Halts the core |
| sr_req | output | 1 | Self-refresh request |
| sdram_off | output | 1 | Memory power removed |
| clk_stop | output | 1 | Clock gating enable |
| pll_pd | output | 1 | PLL power-down |
| clkgen_off | output | 1 | Clock generator off |
| pstate | output | 3 | Committed power state code |
| busy | output | 1 | Transition in progress |
| lock_timeout | output | 1 | Sticky lock timeout flag |

## Verification
A wrong sequencer state appears at the ports in the same cycle, as a control combination that no state table row allows. Examples are clocks gated while memory is not yet in self-refresh, or self-refresh released while clocks are still gated. A lost state, such as a stored clock mode that is wrong, shows up at the next wake: the exit takes the wrong path, or fails to restart the PLL, within a few cycles. Watchers at the ports catch ordering errors on the cycle they occur. Wrong target decoding shows as a mismatched control vector once the sequence settles.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    localparam int SYS_W = 3;
    localparam int CPU_W = 2;
    localparam int PS_W  = 3;

    typedef enum logic [PS_W-1:0] {
        PS_NORMAL = 3'd0,
        PS_HALT   = 3'd1,
        PS_QUICK  = 3'd2,
        PS_DEEP   = 3'd3,
        PS_OFF    = 3'd4
    } pstate_e;

    typedef enum logic [1:0] {
        CK_RUN    = 2'd0,
        CK_STOP   = 2'd1,
        CK_PLLOFF = 2'd2,
        CK_GENOFF = 2'd3
    } clkmode_e;

    typedef enum logic [1:0] {
        SD_ACTIVE   = 2'd0,
        SD_SELFREF  = 2'd1,
        SD_POWEROFF = 2'd2
    } sdmode_e;

    typedef struct packed {
        pstate_e  ps;
        clkmode_e ck;
        sdmode_e  sd;
    } profile_t;
endpackage

// File: rtl/pwr_req_decode.sv
module pwr_req_decode
    import pwr_seq_pkg::*;
(
    input  logic [SYS_W-1:0] sys_code,
    input  logic [CPU_W-1:0] cpu_code,
    output profile_t         prof
);
    always_comb begin
        prof = '{ps: PS_NORMAL, ck: CK_RUN, sd: SD_ACTIVE};
        case (sys_code)
            3'd0: begin
                unique case (cpu_code)
                    2'd0: prof = '{ps: PS_NORMAL, ck: CK_RUN,  sd: SD_ACTIVE};
                    2'd1: prof = '{ps: PS_HALT,   ck: CK_RUN,  sd: SD_ACTIVE};
                    2'd2: prof = '{ps: PS_QUICK,  ck: CK_RUN,  sd: SD_SELFREF};
                    2'd3: prof = '{ps: PS_DEEP,   ck: CK_STOP, sd: SD_SELFREF};
                endcase
            end
            3'd1:       prof = '{ps: PS_DEEP, ck: CK_PLLOFF, sd: SD_SELFREF};
            3'd2, 3'd3: prof = '{ps: PS_OFF,  ck: CK_PLLOFF, sd: SD_SELFREF};
            default:    prof = '{ps: PS_OFF,  ck: CK_GENOFF, sd: SD_POWEROFF};
        endcase
    end
endmodule

// File: rtl/pwr_lock_timer.sv
module pwr_lock_timer #(
    parameter int LOCK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              lock,
    input  logic [LOCK_W-1:0] limit,
    output logic              expired
);
    logic [LOCK_W-1:0] cnt;
    logic              at_lim;

    assign at_lim = (cnt == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else begin
            if (!run)
                cnt <= '0;
            else if (!at_lim)
                cnt <= cnt + 1'b1;
            if (run && !lock && at_lim)
                expired <= 1'b1;
        end
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  profile_t req_prof,
    input  logic     wake,
    input  logic     sr_ack,
    input  logic     pll_lock,
    output logic     core_halt,
    output logic     sr_req,
    output logic     sdram_off,
    output logic     clk_stop,
    output logic     pll_pd,
    output logic     clkgen_off,
    output pstate_e  cur_ps,
    output logic     busy,
    output logic     lock_wait
);
    typedef enum logic [2:0] {
        SQ_NORMAL, SQ_HALT, SQ_SR_ENTER, SQ_LOWPWR,
        SQ_EXIT_LOCK, SQ_EXIT_CLK, SQ_EXIT_SR
    } seq_e;

    seq_e     state;
    profile_t tgt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_NORMAL;
            cur_ps <= PS_NORMAL;
            tgt    <= '{ps: PS_NORMAL, ck: CK_RUN, sd: SD_ACTIVE};
        end else begin
            unique case (state)
                SQ_NORMAL, SQ_HALT: begin
                    if (state == SQ_HALT && wake) begin
                        state  <= SQ_NORMAL;
                        cur_ps <= PS_NORMAL;
                    end else if (req_valid) begin
                        if (req_prof.sd == SD_ACTIVE) begin
                            state  <= (req_prof.ps == PS_HALT) ? SQ_HALT : SQ_NORMAL;
                            cur_ps <= req_prof.ps;
                        end else begin
                            tgt   <= req_prof;
                            state <= SQ_SR_ENTER;
                        end
                    end
                end
                SQ_SR_ENTER: begin
                    if (sr_ack) begin
                        state  <= SQ_LOWPWR;
                        cur_ps <= tgt.ps;
                    end
                end
                SQ_LOWPWR: begin
                    if (wake) begin
                        unique case (tgt.ck)
                            CK_RUN:    state <= SQ_EXIT_SR;
                            CK_STOP:   state <= SQ_EXIT_CLK;
                            CK_PLLOFF: state <= SQ_EXIT_LOCK;
                            CK_GENOFF: state <= SQ_LOWPWR;
                        endcase
                    end
                end
                SQ_EXIT_LOCK: if (pll_lock) state <= SQ_EXIT_CLK;
                SQ_EXIT_CLK:  state <= SQ_EXIT_SR;
                SQ_EXIT_SR: begin
                    if (!sr_ack) begin
                        state  <= SQ_NORMAL;
                        cur_ps <= PS_NORMAL;
                    end
                end
                default: state <= SQ_NORMAL;
            endcase
        end
    end

    always_comb begin
        core_halt  = 1'b0;
        sr_req     = 1'b0;
        sdram_off  = 1'b0;
        clk_stop   = 1'b0;
        pll_pd     = 1'b0;
        clkgen_off = 1'b0;
        busy       = 1'b0;
        lock_wait  = 1'b0;
        unique case (state)
            SQ_NORMAL: ;
            SQ_HALT:   core_halt = 1'b1;
            SQ_SR_ENTER: begin
                core_halt = 1'b1;
                sr_req    = 1'b1;
                busy      = 1'b1;
            end
            SQ_LOWPWR: begin
                core_halt  = 1'b1;
                sr_req     = 1'b1;
                clk_stop   = (tgt.ck != CK_RUN);
                pll_pd     = (tgt.ck == CK_PLLOFF) || (tgt.ck == CK_GENOFF);
                clkgen_off = (tgt.ck == CK_GENOFF);
                sdram_off  = (tgt.sd == SD_POWEROFF);
            end
            SQ_EXIT_LOCK: begin
                core_halt = 1'b1;
                sr_req    = 1'b1;
                clk_stop  = 1'b1;
                busy      = 1'b1;
                lock_wait = 1'b1;
            end
            SQ_EXIT_CLK: begin
                core_halt = 1'b1;
                sr_req    = 1'b1;
                busy      = 1'b1;
            end
            SQ_EXIT_SR: begin
                core_halt = 1'b1;
                busy      = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
    import pwr_seq_pkg::*;
#(
    parameter int LOCK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_sys,
    input  logic [1:0]        req_cpu,
    input  logic              wake,
    input  logic              sr_ack,
    input  logic              pll_lock,
    input  logic [LOCK_W-1:0] lock_wait_lim,
    output logic              core_halt,
    output logic              sr_req,
    output logic              sdram_off,
    output logic              clk_stop,
    output logic              pll_pd,
    output logic              clkgen_off,
    output logic [2:0]        pstate,
    output logic              busy,
    output logic              lock_timeout
);
    profile_t req_prof;
    pstate_e  cur_ps;
    logic     lock_wait;

    pwr_req_decode u_dec (
        .sys_code (req_sys),
        .cpu_code (req_cpu),
        .prof     (req_prof)
    );

    pwr_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_prof   (req_prof),
        .wake       (wake),
        .sr_ack     (sr_ack),
        .pll_lock   (pll_lock),
        .core_halt  (core_halt),
        .sr_req     (sr_req),
        .sdram_off  (sdram_off),
        .clk_stop   (clk_stop),
        .pll_pd     (pll_pd),
        .clkgen_off (clkgen_off),
        .cur_ps     (cur_ps),
        .busy       (busy),
        .lock_wait  (lock_wait)
    );

    pwr_lock_timer #(.LOCK_W(LOCK_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (lock_wait),
        .lock    (pll_lock),
        .limit   (lock_wait_lim),
        .expired (lock_timeout)
    );

    assign pstate = cur_ps;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       wake,
    input logic       sr_ack,
    input logic       core_halt,
    input logic       sr_req,
    input logic       sdram_off,
    input logic       clk_stop,
    input logic       pll_pd,
    input logic       clkgen_off,
    input logic [2:0] pstate,
    input logic       busy,
    input logic       lock_timeout
);
    AST_PSTATE_LEGAL:   assert property (@(posedge clk) disable iff (!rst_n) pstate <= 3'd4); // R2
    AST_HALT_NO_SEQ:    assert property (@(posedge clk) disable iff (!rst_n) (pstate == 3'd1 && !busy) |-> (core_halt && !sr_req && !clk_stop)); // R3
    AST_CLK_AFTER_ACK:  assert property (@(posedge clk) disable iff (!rst_n) $rose(clk_stop) |-> sr_ack); // R7
    AST_PLL_AFTER_ACK:  assert property (@(posedge clk) disable iff (!rst_n) $rose(pll_pd) |-> sr_ack); // R7
    AST_CLK_AFTER_PLL:  assert property (@(posedge clk) disable iff (!rst_n) $fell(clk_stop) |-> !pll_pd); // R8
    AST_SR_LAST:        assert property (@(posedge clk) disable iff (!rst_n) $fell(sr_req) |-> (!clk_stop && !pll_pd)); // R8
    AST_GENOFF_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) clkgen_off |=> (clkgen_off && sdram_off && $stable(pstate))); // R9
    AST_SR_BUSY:        assert property (@(posedge clk) disable iff (!rst_n) $rose(sr_req) |-> busy); // R10
    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) lock_timeout |=> lock_timeout); // R11
endmodule

bind pwr_state_seq pwr_seq_chk u_chk (.*);

// File: tb/test_pwr_state_seq.sv
module test_pwr_state_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_sys = '0;
    logic [1:0]  req_cpu = '0;
    logic        wake = 1'b0;
    logic        sr_ack;
    logic        pll_lock;
    logic [15:0] lock_wait_lim = 16'd1000;
    logic        core_halt, sr_req, sdram_off, clk_stop, pll_pd, clkgen_off, busy, lock_timeout;
    logic [2:0]  pstate;
    logic        pll_dead = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    int ord7_bad = 0;
    int ord8_bad = 0;

    always #2 clk = ~clk;

    pwr_state_seq i_pwr_state_seq (.*);

    // memory controller model: acknowledge follows request by two cycles
    logic [1:0] sr_pipe;
    always @(posedge clk) begin
        if (!rst_n) sr_pipe <= '0;
        else        sr_pipe <= {sr_pipe[0], sr_req};
    end
    assign sr_ack = sr_pipe[1];

    // PLL model: locks five cycles after power-up
    int lock_cnt = 0;
    always @(posedge clk) begin
        if (pll_pd || pll_dead) lock_cnt <= 0;
        else if (lock_cnt < 5)  lock_cnt <= lock_cnt + 1;
    end
    assign pll_lock = (lock_cnt == 5);

    // ordering watchers (R7, R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if ((clk_stop || pll_pd) && !sr_ack) ord7_bad++;
            if (pll_pd && !clk_stop) ord8_bad++;
            if (clk_stop && !sr_req) ord8_bad++;
        end
    end

    typedef struct {
        logic [10:0] v;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    wire [10:0] obs = {pstate, busy, core_halt, sr_req, clk_stop, pll_pd,
                       clkgen_off, sdram_off, lock_timeout};

    function automatic logic [10:0] mk(int ps, bit b, bit h, bit s, bit cs,
                                       bit pp, bit go, bit so, bit to);
        logic [2:0] p3;
        p3 = ps[2:0];
        return {p3, b, h, s, cs, pp, go, so, to};
    endfunction

    // monitor: pops expected items and compares them with the ports
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (obs !== e.v) begin
                n_fail++;
                $display("FAIL %s: got %b expected %b", e.tag, obs, e.v);
            end
        end
    end

    task automatic expect_vec(logic [10:0] v, string tag);
        exp_t e;
        @(posedge clk);
        #1;
        e.v = v;
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic request(logic [2:0] s, logic [1:0] c);
        @(negedge clk);
        req_valid = 1'b1;
        req_sys = s;
        req_cpu = c;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        for (int i = 0; i < 300 && busy; i++) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): got hung expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        expect_vec(mk(0,0,0,0,0,0,0,0,0), "R1 reset state");
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(posedge clk);

        request(3'd0, 2'd1); settle();
        expect_vec(mk(1,0,1,0,0,0,0,0,0), "R3 C1 auto halt");
        pulse_wake(); settle();
        expect_vec(mk(0,0,0,0,0,0,0,0,0), "R9 wake from halt");

        request(3'd0, 2'd2); settle();
        expect_vec(mk(2,0,1,1,0,0,0,0,0), "R4 C2 quick start");
        request(3'd0, 2'd3); settle();
        expect_vec(mk(2,0,1,1,0,0,0,0,0), "R10 request ignored in low power");
        pulse_wake(); settle();
        expect_vec(mk(0,0,0,0,0,0,0,0,0), "R9 wake from quick start");

        request(3'd0, 2'd3); settle();
        expect_vec(mk(3,0,1,1,1,0,0,0,0), "R5 C3 deep sleep");
        pulse_wake(); settle();
        expect_vec(mk(0,0,0,0,0,0,0,0,0), "R9 wake from C3 deep");

        request(3'd1, 2'd0); settle();
        expect_vec(mk(3,0,1,1,1,1,0,0,0), "R5 S1 deep sleep pll down");
        pulse_wake();
        repeat (2) @(posedge clk);
        expect_vec(mk(3,1,1,1,1,0,0,0,0), "R8 R2 waiting lock keeps code");
        settle();
        expect_vec(mk(0,0,0,0,0,0,0,0,0), "R8 exit S1 to normal");

        request(3'd3, 2'd0); settle();
        expect_vec(mk(4,0,1,1,1,1,0,0,0), "R6 S3 off self refresh");
        pulse_wake(); settle();
        expect_vec(mk(0,0,0,0,0,0,0,0,0), "R9 wake from S3 off");

        // busy-ignore: C2 then C3 while entry is in progress
        request(3'd0, 2'd2);
        request(3'd0, 2'd3);
        settle();
        expect_vec(mk(2,0,1,1,0,0,0,0,0), "R10 request ignored while busy");
        pulse_wake(); settle();

        request(3'd0, 2'd0); settle();
        expect_vec(mk(0,0,0,0,0,0,0,0,0), "R3 C0 stays normal");

        // lock timeout
        lock_wait_lim = 16'd20;
        pll_dead = 1'b1;
        request(3'd1, 2'd0); settle();
        pulse_wake();
        repeat (40) @(posedge clk);
        expect_vec(mk(3,1,1,1,1,0,0,0,1), "R11 lock timeout flagged");
        pll_dead = 1'b0;
        settle();
        expect_vec(mk(0,0,0,0,0,0,0,0,1), "R11 late lock completes, flag sticky");

        request(3'd5, 2'd0); settle();
        expect_vec(mk(4,0,1,1,1,1,1,1,1), "R6 S5 off generator off");
        pulse_wake(); repeat (20) @(posedge clk);
        expect_vec(mk(4,0,1,1,1,1,1,1,1), "R9 wake ignored in hard off");

        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(posedge clk);
        expect_vec(mk(0,0,0,0,0,0,0,0,0), "R1 reset leaves hard off");

        n_chk++;
        if (ord7_bad != 0) begin
            n_fail++;
            $display("FAIL R7 entry order: got %0d violations expected 0", ord7_bad);
        end
        n_chk++;
        if (ord8_bad != 0) begin
            n_fail++;
            $display("FAIL R8 exit order: got %0d violations expected 0", ord8_bad);
        end

        summary();
        $finish;
    end
endmodule